// File: doc/BRIEF.md
# Channel Loopback Check-Word Self-Test

This block is the board-test engine of a parallel channel receiver. While the host keeps it in its test mode, it stands in for a live connection. It raises its connect output, takes in framed bursts of 32-bit words with one parity bit per byte, and folds every accepted word into a longitudinal check word, which is the bitwise XOR of all words in the burst. When a burst closes, the host's expected check word for that burst is captured. On the following cycle it is compared with the value the block built itself.

Matching bursts leave the link up, so the test runs burst after burst until the host changes the mode. The first miscompare tears down the simulated connection: the connect output falls and a sticky miscompare flag rises. Both stay that way until the host applies the reset mode and then selects the test mode again. Byte parity faults are reported on a separate sticky flag and do not end the test.

Top module: `chan_selftest`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears itself: after that edge `conn_out`, `miscmp` and `par_err` are all 0.
- R2: With no miscompare latched, `mode` = 2'b11 (test) at a clock edge makes `conn_out` 1 after that edge. The link never comes up under any other mode value.
- R3: The check word of a burst is the XOR of every word accepted since the previous burst end, the closing word included, starting from zero for each burst. A word is accepted when `word_valid` is 1 while the link is up, and the closing word is the one accepted with `burst_end` = 1. If `exp_llrc`, sampled with the closing word, equals the check word, the link stays up and the next burst starts fresh.
- R4: If the sampled `exp_llrc` differs from the check word, `conn_out` is still 1 after the edge that accepts the closing word. `conn_out` falls to 0 and `miscmp` rises to 1 after the next edge. The two outputs are never 1 together.
- R5: After a miscompare, `conn_out` stays 0 and `miscmp` stays 1 under every nonzero mode value, including a return to test mode, and later bursts have no effect.
- R6: `mode` = 2'b00 (reset) at an edge clears `miscmp` and `par_err` and drops `conn_out`. Selecting test mode afterwards brings the link up again.
- R7: Switching from test mode to 2'b01 or 2'b10 drops `conn_out` after the next edge and discards any partly built check word. A later return to test mode starts a fresh burst. This does not clear `miscmp` or `par_err`.
- R8: Parity bit `par[i]` is odd parity over `data[8i+7:8i]`, so each byte together with its parity bit holds an odd number of ones. An accepted word failing this on any byte sets `par_err` after its edge. `par_err` stays set until the reset mode, and the link stays up.
- R9: Cycles with `word_valid` = 0 are ignored whatever `data`, `par`, `burst_end` and `exp_llrc` carry.
- R10: While the link is down, words are not accepted: they cause no parity flag and no compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 reset, 01/10 test off, 11 board test |
| word_valid | input | 1 | Burst word strobe |
| burst_end | input | 1 | Marks the closing word of a burst |
| data | input | 32 | Data word |
| par | input | 4 | Odd parity per data byte |
| exp_llrc | input | 32 | Host's expected check word, sampled with the closing word |
| conn_out | output | 1 | Simulated connection active |
| miscmp | output | 1 | Sticky miscompare flag |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The bench targets four corner cases. The first is single-word bursts, where a design that fails to seed from zero would carry the previous burst's value forward. The second is bursts split by idle cycles that carry junk data and a stray `burst_end`; a design that ignores the strobe would fold junk in or close the burst early. The third is the exact cycle `conn_out` falls after a bad check word, which catches designs that drop it a cycle early or late. The fourth is test-mode reentry after a miscompare, where a design that clears the lock on any mode change would wrongly reconnect. The bench also leaves test mode in the middle of a burst, which exposes a stale partial check word, and sends bad-parity words while the link is down, which must not set the flag.

// File: rtl/chst_pkg.sv
// Shared types and mode codes for the channel self-test block.
// Assumes a two-bit mode input; the codes below are behaviour, not layout.
package chst_pkg;
    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_RESET = 2'b00;
    localparam logic [MODE_W-1:0] MODE_TEST  = 2'b11;

    typedef enum logic [1:0] {
        LINK_OFF  = 2'b00,
        LINK_UP   = 2'b01,
        LINK_FAIL = 2'b10
    } link_t;
endpackage

// File: rtl/chst_parity.sv
// Per-lane odd parity checker.
// Each lane of LANE_W data bits plus its parity bit must hold an odd
// number of ones. Purely combinational; qualification is done by the caller.
module chst_parity #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int NLANE = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [NLANE-1:0]  par,
    output logic              any_bad
);
    logic [NLANE-1:0] lane_bad;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // Lane is bad when data plus parity has an even count of ones.
        always_comb lane_bad[g] = ~(^{data[g*LANE_W +: LANE_W], par[g]});
    end

    // Any failing lane flags the word.
    always_comb any_bad = |lane_bad;
endmodule

// File: rtl/chst_accum.sv
// Check-word accumulator and compare stage.
// XORs accepted words from a zero seed; on the closing word it stores the
// final value and the host's expected word, and presents the compare result
// one cycle later. Assumes the caller gates word_ok with the link state.
module chst_accum #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              word_ok,
    input  logic              last,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] exp_word,
    output logic              cmp_bad
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] sum_q;
    logic [DATA_W-1:0] exp_q;
    logic              pend_q;

    // Running XOR, end-of-burst capture and compare-pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q  <= '0;
            sum_q  <= '0;
            exp_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= word_ok && last;
            if (word_ok) begin
                if (last) begin
                    sum_q <= acc_q ^ data;
                    exp_q <= exp_word;
                    acc_q <= '0;
                end else begin
                    acc_q <= acc_q ^ data;
                end
            end
        end
    end

    // Miscompare seen in the cycle after the closing word.
    always_comb cmp_bad = pend_q && (sum_q != exp_q);
endmodule

// File: rtl/chst_ctrl.sv
// Link state machine and sticky parity flag.
// Priority: reset mode, then leaving test mode, then a miscompare.
// A failed link is left only through the reset mode.
module chst_ctrl
    import chst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              cmp_bad,
    input  logic              par_hit,
    output logic              linked,
    output logic              conn_out,
    output logic              miscmp,
    output logic              par_err
);
    link_t state_q;
    link_t state_d;
    logic  par_q;

    // Next link state from mode and compare result.
    always_comb begin
        state_d = state_q;
        if (mode == MODE_RESET) begin
            state_d = LINK_OFF;
        end else begin
            case (state_q)
                LINK_OFF:  if (mode == MODE_TEST) state_d = LINK_UP;
                LINK_UP:   begin
                    if (mode != MODE_TEST) state_d = LINK_OFF;
                    else if (cmp_bad)      state_d = LINK_FAIL;
                end
                LINK_FAIL: state_d = LINK_FAIL;
                default:   state_d = LINK_OFF;
            endcase
        end
    end

    // Link state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINK_OFF;
        else        state_q <= state_d;
    end

    // Sticky parity flag, cleared by reset or the reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_RESET) par_q <= 1'b0;
        else if (par_hit)                 par_q <= 1'b1;
    end

    // Output decode.
    always_comb begin
        linked   = (state_q == LINK_UP);
        conn_out = linked;
        miscmp   = (state_q == LINK_FAIL);
        par_err  = par_q;
    end
endmodule

// File: rtl/chan_selftest.sv
// Top of the channel loopback self-test block.
// Accepts words only while the simulated link is up; everything arriving
// while it is down is dropped and leaves no trace.
module chan_selftest
    import chst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int NLANE = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              word_valid,
    input  logic              burst_end,
    input  logic [DATA_W-1:0] data,
    input  logic [NLANE-1:0]  par,
    input  logic [DATA_W-1:0] exp_llrc,
    output logic              conn_out,
    output logic              miscmp,
    output logic              par_err
);
    logic linked;
    logic word_ok;
    logic lane_fault;
    logic cmp_bad;
    logic par_hit;

    // Qualify words with the link state.
    always_comb begin
        word_ok = word_valid && linked;
        par_hit = word_ok && lane_fault;
    end

    chst_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_par (
        .data    (data),
        .par     (par),
        .any_bad (lane_fault)
    );

    chst_accum #(.DATA_W(DATA_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!linked),
        .word_ok  (word_ok),
        .last     (burst_end),
        .data     (data),
        .exp_word (exp_llrc),
        .cmp_bad  (cmp_bad)
    );

    chst_ctrl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cmp_bad  (cmp_bad),
        .par_hit  (par_hit),
        .linked   (linked),
        .conn_out (conn_out),
        .miscmp   (miscmp),
        .par_err  (par_err)
    );
endmodule

// File: rtl/chst_checker.sv
// Port-level protocol checks for chan_selftest, attached by bind.
module chst_checker
    import chst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic              conn_out,
    input logic              miscmp,
    input logic              par_err
);
    AST_CONN_NEEDS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conn_out) |-> $past(mode) == MODE_TEST);                        // R2
    AST_FAIL_FROM_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miscmp) |-> $past(conn_out));                                   // R4
    AST_LINK_XOR_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !(conn_out && miscmp));                                               // R4
    AST_FAIL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (miscmp && mode != MODE_RESET) |=> (miscmp && !conn_out));            // R5
    AST_RESET_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RESET) |=> (!conn_out && !miscmp && !par_err));         // R6
    AST_EXIT_DROPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_out && mode != MODE_TEST) |=> !conn_out);                       // R7
    AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && mode != MODE_RESET) |=> par_err);                         // R8
    AST_PAR_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> $past(conn_out));                                  // R10
endmodule

bind chan_selftest chst_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .conn_out (conn_out),
    .miscmp   (miscmp),
    .par_err  (par_err)
);

// File: tb/chan_selftest_tb.sv
`timescale 1ns/1ps
module chan_selftest_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        word_valid = 1'b0;
    logic        burst_end = 1'b0;
    logic [31:0] data = '0;
    logic [3:0]  par = '0;
    logic [31:0] exp_llrc = '0;
    logic        conn_out, miscmp, par_err;

    int nchk = 0;
    int nfail = 0;
    bit mdl_conn = 0, mdl_fail = 0, mdl_par = 0;
    int unsigned seed_sink;

    always #2.5 clk = ~clk;

    chan_selftest u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .word_valid(word_valid),
        .burst_end(burst_end), .data(data), .par(par), .exp_llrc(exp_llrc),
        .conn_out(conn_out), .miscmp(miscmp), .par_err(par_err)
    );

    function automatic logic [3:0] odd_par(logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ~(^d[i*8 +: 8]);
        return p;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        check(tag, "conn_out", conn_out, mdl_conn);
        check(tag, "miscmp", miscmp, mdl_fail);
        check(tag, "par_err", par_err, mdl_par);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        word_valid = 1'b0;
        burst_end  = $urandom_range(0, 1);
        data       = $urandom;
        par        = $urandom_range(0, 15);
        exp_llrc   = $urandom;
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode = m;
        word_valid = 1'b0;
        burst_end = 1'b0;
        @(negedge clk);
        if (m == 2'b00) begin
            mdl_conn = 0; mdl_fail = 0; mdl_par = 0;
        end else if (m == 2'b11) begin
            mdl_conn = !mdl_fail;
        end else begin
            mdl_conn = 0;
        end
    endtask

    // Sends one burst; bad_idx >= 0 corrupts one parity bit on that word.
    task automatic send_burst(int len, bit corrupt, int bad_idx, bit gaps, string tag);
        logic [31:0] acc = '0;
        logic [31:0] d;
        bit was_conn = mdl_conn;
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom_range(0, 2) == 0)) idle_cycle();
            d = $urandom;
            acc ^= d;
            @(negedge clk);
            word_valid = 1'b1;
            data       = d;
            par        = odd_par(d) ^ ((i == bad_idx) ? (4'b1 << $urandom_range(0, 3)) : 4'b0);
            burst_end  = (i == len - 1);
            exp_llrc   = (i == len - 1) ? (acc ^ (corrupt ? (32'h1 << $urandom_range(0, 31)) : 32'h0))
                                        : $urandom;
        end
        @(negedge clk);
        word_valid = 1'b0;
        burst_end  = 1'b0;
        check("R4", {tag, " link held through last-word edge"}, conn_out, was_conn);
        @(negedge clk);
        if (was_conn) begin
            if (bad_idx >= 0) mdl_par = 1;
            if (corrupt) begin
                mdl_conn = 0; mdl_fail = 1;
            end
        end
        check_outs(tag);
    endtask

    initial begin
        seed_sink = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        check_outs("R1");
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1");

        // R2: link comes up in test mode only
        set_mode(2'b01); check_outs("R2");
        set_mode(2'b11); check_outs("R2");

        // R3: matching bursts, single word and multi word, keep link up
        send_burst(1, 0, -1, 0, "R3");
        send_burst(5, 0, -1, 0, "R3");
        send_burst(1, 0, -1, 0, "R3");

        // R9: gaps carrying junk and stray burst_end are ignored
        send_burst(6, 0, -1, 1, "R9");

        // R8: bad parity sets sticky flag, link stays
        send_burst(3, 0, 1, 0, "R8");
        send_burst(2, 0, -1, 0, "R8");

        // R7: leave test mode mid burst, partial word discarded
        @(negedge clk);
        word_valid = 1'b1; data = 32'hDEAD_BEEF; par = odd_par(32'hDEAD_BEEF); burst_end = 1'b0;
        set_mode(2'b10); check_outs("R7");
        set_mode(2'b11); check_outs("R7");
        send_burst(3, 0, -1, 0, "R7");

        // R6: reset mode clears parity flag
        set_mode(2'b00); check_outs("R6");
        set_mode(2'b11); check_outs("R6");

        // R4: mismatch drops the link one edge after the closing word
        send_burst(4, 1, -1, 0, "R4");

        // R5: lock persists through bursts and mode changes
        send_burst(3, 0, 2, 0, "R5");
        set_mode(2'b01); check_outs("R5");
        set_mode(2'b11); check_outs("R5");

        // R6: reset mode recovers
        set_mode(2'b00); check_outs("R6");
        set_mode(2'b11); check_outs("R6");

        // R10: link down, bad words and bad compare ignored
        set_mode(2'b01);
        send_burst(3, 1, 0, 0, "R10");
        set_mode(2'b11); check_outs("R10");

        // Random phase
        for (int n = 0; n < 60; n++) begin
            int len = $urandom_range(1, 7);
            bit cor = ($urandom_range(0, 99) < 15);
            int bad = ($urandom_range(0, 99) < 12) ? $urandom_range(0, len - 1) : -1;
            send_burst(len, cor, bad, 1, "R3");
            if (mdl_fail) begin
                set_mode(2'b11); check_outs("R5");
                set_mode(2'b00); check_outs("R6");
                set_mode(2'b11); check_outs("R6");
            end else if ($urandom_range(0, 9) == 0) begin
                set_mode(2'b01); check_outs("R7");
                set_mode(2'b11); check_outs("R7");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule